// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the per-channel address and transfer-count registers of a five-channel DMA controller. Software programs a peripheral address, a memory address and a 16-bit transfer count for each channel through a simple word-wide register port. The channel enable, circular-mode bit and peripheral width code come in from the controller's control registers, which live elsewhere. The transfer engine reads the addresses from this block, issues a transfer only while the matching `xfer_ok` bit is high, and strobes `xfer_done` once per completed transfer.

Each channel has a small state machine with three states. In CH_IDLE the channel is disabled and its registers may be written. CH_RUN means the channel is enabled and has transfers left, and CH_HALT means it is enabled with a working count of zero. The transitions are these. CH_IDLE goes to CH_RUN on enable when the programmed count is nonzero, and to CH_HALT on enable when it is zero. CH_RUN goes to CH_HALT when the last transfer finishes in non-circular mode. CH_RUN stays in CH_RUN when the last transfer finishes in circular mode, and the count reloads. CH_RUN and CH_HALT both return to CH_IDLE on disable. The working count is loaded from the programmed value on the CH_IDLE to enabled transition. The peripheral address leaves the block with its low bits cleared to match the width code.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every address and count register reads zero, and `xfer_ok`, `xfer_cmpl` and `periph_addr` are all zero.
- R2: Channel c has three registers: the count at byte offset 0x0C+0x14·c, the peripheral address at 0x10+0x14·c and the memory address at 0x14+0x14·c. Reads are combinational on `bus_addr`. The count keeps the low 16 bits of a write, and its upper 16 read bits are zero.
- R3: Any offset other than those fifteen, including every offset that is not a multiple of 4, reads as zero, and a write to it changes no register.
- R4: While `ch_en[c]` is 1, writes to channel c's count, peripheral address and memory address registers are ignored.
- R5: A count write accepted while the channel is disabled sets both the programmed and the working count. A count read always returns the working count.
- R6: When `ch_en[c]` rises, the working count loads from the programmed count.
- R7: `xfer_ok[c]` is 1 exactly while the channel is enabled and its working count is nonzero. It rises in the cycle after `ch_en[c]` is sampled high.
- R8: Each `xfer_done[c]` sampled while `xfer_ok[c]` is 1 lowers the working count by one. A strobe sampled while `xfer_ok[c]` is 0 changes nothing.
- R9: `xfer_cmpl[c]` is high for exactly one cycle, in the cycle after the strobe that ended the count.
- R10: In non-circular mode (`ch_circ[c]`=0) the count then stays at zero with `xfer_ok[c]` low until the channel is disabled and enabled again.
- R11: In circular mode (`ch_circ[c]`=1) the final strobe reloads the programmed count and `xfer_ok[c]` stays high.
- R12: `periph_addr` slice c is the programmed peripheral address. With width code `ch_pwidth[2c+1:2c]` = 01, bit 0 is cleared. With code 10 or 11, bits 1:0 are cleared. With code 00, the address passes unchanged.
- R13: `mem_addr` slice c is the programmed memory address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| ch_en | input | 5 | Channel enable bits |
| ch_circ | input | 5 | Circular-mode bits |
| ch_pwidth | input | 10 | Peripheral width code, 2 bits per channel |
| xfer_done | input | 5 | One pulse per completed transfer |
| xfer_ok | output | 5 | Transfer allowed |
| xfer_cmpl | output | 5 | One-cycle completion pulse |
| periph_addr | output | 160 | Width-aligned peripheral addresses, 32 bits per channel |
| mem_addr | output | 160 | Memory addresses, 32 bits per channel |

## Verification
The assertions assume that `xfer_done` comes only from an engine that respects `xfer_ok`. The decrement check is therefore qualified by `xfer_ok` and `ch_en` in the previous cycle, and it makes no claim about strobes that arrive while a channel is idle. They also take the control inputs as stable across a clock edge. The bench drives every input, including the enables, width codes and strobes, at the falling edge, so each one is sampled once and cleanly. It applies strobes to idle and halted channels only to confirm at the ports that they are ignored.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_RUN,
        CH_HALT
    } ch_state_t;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_COUNT,
        RK_PADDR,
        RK_MADDR
    } reg_kind_t;

    localparam int unsigned WIN_BASE   = 8;
    localparam int unsigned WIN_STRIDE = 20;
    localparam int unsigned OFS_COUNT  = 4;
    localparam int unsigned OFS_PADDR  = 8;
    localparam int unsigned OFS_MADDR  = 12;

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
    import dma_regs_pkg::*;
#(
    parameter int unsigned NCH = 5,
    parameter int unsigned AW  = 8,
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [CW-1:0] hit_ch,
    output reg_kind_t     kind
);

    always_comb begin
        hit    = 1'b0;
        hit_ch = '0;
        kind   = RK_NONE;
        for (int c = 0; c < NCH; c++) begin
            if (int'(addr) == int'(WIN_BASE + WIN_STRIDE * c + OFS_COUNT)) begin
                hit = 1'b1; hit_ch = CW'(c); kind = RK_COUNT;
            end
            if (int'(addr) == int'(WIN_BASE + WIN_STRIDE * c + OFS_PADDR)) begin
                hit = 1'b1; hit_ch = CW'(c); kind = RK_PADDR;
            end
            if (int'(addr) == int'(WIN_BASE + WIN_STRIDE * c + OFS_MADDR)) begin
                hit = 1'b1; hit_ch = CW'(c); kind = RK_MADDR;
            end
        end
    end

endmodule

// File: rtl/dma_ch_count.sv
module dma_ch_count
    import dma_regs_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             circ,
    input  logic [CNT_W-1:0] prog,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wval,
    input  logic             done_in,
    output logic [CNT_W-1:0] work,
    output logic             ok,
    output logic             cmpl
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ch_state_t state_q, state_d;
    logic      last_xfer;

    assign last_xfer = (state_q == CH_RUN) && en && done_in && (work == ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (en) state_d = (prog != '0) ? CH_RUN : CH_HALT;
            CH_RUN: begin
                if (!en)                   state_d = CH_IDLE;
                else if (last_xfer && !circ) state_d = CH_HALT;
            end
            CH_HALT: if (!en) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work <= '0;
            cmpl <= 1'b0;
        end else begin
            cmpl <= last_xfer;
            if (cnt_wr) begin
                work <= cnt_wval;
            end else begin
                unique case (state_q)
                    CH_IDLE: if (en) work <= prog;
                    CH_RUN: begin
                        if (en && done_in)
                            work <= (last_xfer && circ) ? prog : work - ONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ok = (state_q == CH_RUN);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int unsigned NCH   = 5,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_circ,
    input  logic [2*NCH-1:0]  ch_pwidth,
    input  logic [NCH-1:0]    xfer_done,
    output logic [NCH-1:0]    xfer_ok,
    output logic [NCH-1:0]    xfer_cmpl,
    output logic [NCH*DW-1:0] periph_addr,
    output logic [NCH*DW-1:0] mem_addr
);

    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

    logic          hit;
    logic [CW-1:0] hit_ch;
    reg_kind_t     kind;

    logic [DW-1:0]    paddr_q [NCH];
    logic [DW-1:0]    maddr_q [NCH];
    logic [CNT_W-1:0] prog_q  [NCH];
    logic [CNT_W-1:0] work_a  [NCH];

    logic [NCH*CNT_W-1:0] work_all;
    logic [NCH*DW-1:0]    paddr_all;

    dma_reg_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .addr   (bus_addr),
        .hit    (hit),
        .hit_ch (hit_ch),
        .kind   (kind)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic       sel;
        logic       wr_cnt;
        logic [1:0] pw;

        assign sel    = bus_we && hit && (hit_ch == CW'(c)) && !ch_en[c];
        assign wr_cnt = sel && (kind == RK_COUNT);
        assign pw     = ch_pwidth[2*c +: 2];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                paddr_q[c] <= '0;
                maddr_q[c] <= '0;
                prog_q[c]  <= '0;
            end else if (sel) begin
                if (kind == RK_PADDR) paddr_q[c] <= bus_wdata;
                if (kind == RK_MADDR) maddr_q[c] <= bus_wdata;
                if (kind == RK_COUNT) prog_q[c]  <= bus_wdata[CNT_W-1:0];
            end
        end

        dma_ch_count #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[c]),
            .circ     (ch_circ[c]),
            .prog     (prog_q[c]),
            .cnt_wr   (wr_cnt),
            .cnt_wval (bus_wdata[CNT_W-1:0]),
            .done_in  (xfer_done[c]),
            .work     (work_a[c]),
            .ok       (xfer_ok[c]),
            .cmpl     (xfer_cmpl[c])
        );

        always_comb begin
            periph_addr[c*DW +: DW] = paddr_q[c];
            unique case (pw)
                2'b01:   periph_addr[c*DW]      = 1'b0;
                2'b10,
                2'b11:   periph_addr[c*DW +: 2] = 2'b00;
                default: ;
            endcase
        end

        assign mem_addr[c*DW +: DW]     = maddr_q[c];
        assign work_all[c*CNT_W +: CNT_W] = work_a[c];
        assign paddr_all[c*DW +: DW]    = paddr_q[c];
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (kind)
                RK_COUNT: bus_rdata = DW'(work_a[hit_ch]);
                RK_PADDR: bus_rdata = paddr_q[hit_ch];
                RK_MADDR: bus_rdata = maddr_q[hit_ch];
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk #(
    parameter int unsigned NCH   = 5,
    parameter int unsigned DW    = 32,
    parameter int unsigned CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       ch_en,
    input logic [2*NCH-1:0]     ch_pwidth,
    input logic [NCH-1:0]       xfer_done,
    input logic [NCH-1:0]       xfer_ok,
    input logic [NCH-1:0]       xfer_cmpl,
    input logic [NCH*DW-1:0]    periph_addr,
    input logic [NCH*DW-1:0]    paddr_all,
    input logic [NCH*CNT_W-1:0] work_all
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk

        assert_ok_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_ok[c] |-> (work_all[c*CNT_W +: CNT_W] != '0));

        assert_ok_after_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!ch_en[c]) |-> !xfer_ok[c]);

        assert_paddr_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ch_en[c]) |-> $stable(paddr_all[c*DW +: DW]));

        assert_cmpl_follows_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_cmpl[c] |-> ($past(xfer_done[c]) && $past(xfer_ok[c])));

        assert_decrement_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(xfer_ok[c]) && $past(ch_en[c]) && $past(xfer_done[c]) &&
             $past(work_all[c*CNT_W +: CNT_W]) > CNT_W'(1))
            |-> (work_all[c*CNT_W +: CNT_W] == $past(work_all[c*CNT_W +: CNT_W]) - CNT_W'(1)));

        assert_half_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_pwidth[2*c +: 2] == 2'b01) |-> !periph_addr[c*DW]);

        assert_word_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
            ch_pwidth[2*c+1] |-> (periph_addr[c*DW +: 2] == 2'b00));
    end

endmodule

bind dma_chan_regs dma_regs_chk #(.NCH(NCH), .DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en       (ch_en),
    .ch_pwidth   (ch_pwidth),
    .xfer_done   (xfer_done),
    .xfer_ok     (xfer_ok),
    .xfer_cmpl   (xfer_cmpl),
    .periph_addr (periph_addr),
    .paddr_all   (paddr_all),
    .work_all    (work_all)
);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [4:0]   ch_en = '0;
    logic [4:0]   ch_circ = '0;
    logic [9:0]   ch_pwidth = '0;
    logic [4:0]   xfer_done = '0;
    logic [4:0]   xfer_ok;
    logic [4:0]   xfer_cmpl;
    logic [159:0] periph_addr;
    logic [159:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en),
        .ch_circ(ch_circ), .ch_pwidth(ch_pwidth), .xfer_done(xfer_done),
        .xfer_ok(xfer_ok), .xfer_cmpl(xfer_cmpl), .periph_addr(periph_addr),
        .mem_addr(mem_addr)
    );

    function automatic logic [7:0] cnt_ofs(int c);   return 8'(12 + 20*c); endfunction
    function automatic logic [7:0] pad_ofs(int c);   return 8'(16 + 20*c); endfunction
    function automatic logic [7:0] mad_ofs(int c);   return 8'(20 + 20*c); endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_en(int c, logic v);
        @(negedge clk);
        ch_en[c] = v;
        @(negedge clk);
    endtask

    task automatic strobe(int c);
        @(negedge clk);
        xfer_done[c] = 1'b1;
        @(negedge clk);
        xfer_done[c] = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(cnt_ofs(0), d); chk("R1 count0", d, 0);
        rd(pad_ofs(4), d); chk("R1 paddr4", d, 0);
        rd(mad_ofs(2), d); chk("R1 maddr2", d, 0);
        chk("R1 xfer_ok", 32'(xfer_ok), 0);
        chk("R1 xfer_cmpl", 32'(xfer_cmpl), 0);
        chk("R1 periph_addr", periph_addr[31:0] | periph_addr[159:128], 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(pad_ofs(4), 32'h8000_0010);
        wr(mad_ofs(4), 32'h2000_0400);
        wr(cnt_ofs(1), 32'hABCD_0003);
        rd(pad_ofs(4), d); chk("R2 paddr4", d, 32'h8000_0010);
        rd(mad_ofs(4), d); chk("R2 maddr4", d, 32'h2000_0400);
        rd(cnt_ofs(1), d); chk("R2 R5 count1 low half", d, 32'h0000_0003);
        chk("R13 mem_addr4", mem_addr[4*32 +: 32], 32'h2000_0400);
    endtask

    task automatic t_decode;
        logic [31:0] d;
        wr(8'h61, 32'hDEAD_BEEF);
        rd(pad_ofs(4), d); chk("R3 misaligned write no effect", d, 32'h8000_0010);
        rd(8'h61, d); chk("R3 misaligned read", d, 0);
        wr(8'h68, 32'h1234_5678);
        rd(8'h68, d); chk("R3 out of range read", d, 0);
        rd(8'h08, d); chk("R3 control slot read", d, 0);
        rd(mad_ofs(4), d); chk("R3 maddr4 untouched", d, 32'h2000_0400);
    endtask

    task automatic t_align;
        wr(pad_ofs(2), 32'h1234_5677);
        @(negedge clk); ch_pwidth[5:4] = 2'b00; #1;
        chk("R12 width 00", periph_addr[64 +: 32], 32'h1234_5677);
        @(negedge clk); ch_pwidth[5:4] = 2'b01; #1;
        chk("R12 width 01", periph_addr[64 +: 32], 32'h1234_5676);
        @(negedge clk); ch_pwidth[5:4] = 2'b10; #1;
        chk("R12 width 10", periph_addr[64 +: 32], 32'h1234_5674);
        @(negedge clk); ch_pwidth[5:4] = 2'b11; #1;
        chk("R12 width 11", periph_addr[64 +: 32], 32'h1234_5674);
        @(negedge clk); ch_pwidth[5:4] = 2'b00;
    endtask

    task automatic t_lock;
        logic [31:0] d;
        wr(mad_ofs(2), 32'hCAFE_F00D);
        wr(cnt_ofs(2), 32'd5);
        set_en(2, 1'b1);
        wr(pad_ofs(2), 32'hFFFF_FFFF);
        wr(mad_ofs(2), 32'h0);
        wr(cnt_ofs(2), 32'd9);
        rd(pad_ofs(2), d); chk("R4 paddr locked", d, 32'h1234_5677);
        rd(mad_ofs(2), d); chk("R4 maddr locked", d, 32'hCAFE_F00D);
        rd(cnt_ofs(2), d); chk("R4 count locked", d, 32'd5);
        chk("R13 mem_addr2", mem_addr[64 +: 32], 32'hCAFE_F00D);
        set_en(2, 1'b0);
    endtask

    task automatic t_zero;
        logic [31:0] d;
        set_en(3, 1'b1);
        chk("R7 zero count blocks", 32'(xfer_ok[3]), 0);
        strobe(3);
        chk("R8 strobe on halted", 32'(xfer_cmpl[3]), 0);
        rd(cnt_ofs(3), d); chk("R8 zero count stays", d, 0);
        set_en(3, 1'b0);
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        strobe(1);
        rd(cnt_ofs(1), d); chk("R8 idle strobe ignored", d, 3);
        set_en(1, 1'b1);
        chk("R6 R7 ok after enable", 32'(xfer_ok[1]), 1);
        strobe(1); chk("R9 no early cmpl", 32'(xfer_cmpl[1]), 0);
        rd(cnt_ofs(1), d); chk("R8 count 2", d, 2);
        strobe(1);
        rd(cnt_ofs(1), d); chk("R8 count 1", d, 1);
        strobe(1);
        chk("R9 cmpl pulse", 32'(xfer_cmpl[1]), 1);
        chk("R10 ok dropped", 32'(xfer_ok[1]), 0);
        @(negedge clk);
        chk("R9 cmpl one cycle", 32'(xfer_cmpl[1]), 0);
        strobe(1);
        rd(cnt_ofs(1), d); chk("R10 stays zero", d, 0);
        chk("R10 no second cmpl", 32'(xfer_cmpl[1]), 0);
        set_en(1, 1'b0);
        set_en(1, 1'b1);
        rd(cnt_ofs(1), d); chk("R6 reload on enable", d, 3);
        chk("R7 ok again", 32'(xfer_ok[1]), 1);
        set_en(1, 1'b0);
        chk("R7 ok low when disabled", 32'(xfer_ok[1]), 0);
    endtask

    task automatic t_circular;
        logic [31:0] d;
        wr(cnt_ofs(0), 32'd2);
        @(negedge clk); ch_circ[0] = 1'b1;
        set_en(0, 1'b1);
        strobe(0);
        strobe(0);
        chk("R11 cmpl in circular", 32'(xfer_cmpl[0]), 1);
        chk("R11 ok stays high", 32'(xfer_ok[0]), 1);
        rd(cnt_ofs(0), d); chk("R11 count reloaded", d, 2);
        strobe(0);
        rd(cnt_ofs(0), d); chk("R11 R8 continues", d, 1);
        set_en(0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map;
        t_decode;
        t_align;
        t_lock;
        t_zero;
        t_oneshot;
        t_circular;
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule